// File: doc/BRIEF.md
# SAR ADC serial read controller

This block is the host-side master for a 14-bit successive-approximation converter reached over three wires. The controller drives a conversion-start line and a serial clock, and it receives one serial data line. When it accepts a sample request, it raises the conversion line and holds it there for a programmable minimum conversion time. It then lowers the line and clocks the result in MSB first, with no pipeline delay. The word comes out on a parallel bus together with a one-cycle valid strobe.

The controller can also put the converter into its low-power states. It does this by pulsing the conversion line a fixed number of times while the serial clock stays still: two pulses for a light nap and four pulses for deep sleep. After deep sleep, the next sample request first sends a wake pulse. The controller then waits a programmable recovery time before it runs the conversion that it reports. Every duration is a parameter counted in system clock cycles. These are the conversion time C, the serial clock half period H, the gap between power pulses G and the sleep recovery time W.

Top module: `sar_read_ctrl`

## Requirements
- R1: While reset is held and right after its release, `conv_o`, `sck_o`, `valid_o` and `busy_o` are all low.
- R2: Every high phase of `conv_o` lasts exactly C cycles, and `sck_o` is low whenever `conv_o` is high.
- R3: After `conv_o` falls in a read, `sck_o` makes exactly DATA_W rising and DATA_W falling edges. Each high phase lasts H cycles. The clock then idles low.
- R4: The bit on `sdo_i` after `conv_o` falls becomes `data_o[DATA_W-1]`. The bit after the k-th `sck_o` falling edge becomes `data_o[DATA_W-1-k]`. Whatever follows the final falling edge is ignored.
- R5: `valid_o` is high for exactly one cycle, C + 2·DATA_W·H clock edges after the edge that accepted `start_i`. `data_o` holds its value until the next valid strobe.
- R6: `busy_o` is high from the accepting edge until the edge that raises `valid_o` (or ends a power command), and it is low in the valid cycle.
- R7: A nap request gives 2 `conv_o` pulses (C high, G low) with `sck_o` low and no valid strobe. `busy_o` stays high for 2·(C+G) cycles. The next read runs with normal latency and no added wait.
- R8: A sleep request gives 4 such pulses with `sck_o` low. `busy_o` stays high for 4·(C+G) cycles.
- R9: The first read after a sleep (even if a nap came in between) sends one wake pulse of C cycles. It then keeps `conv_o` low for W cycles before the real conversion. Its valid strobe comes C + W + C + 2·DATA_W·H edges after acceptance. Later reads return to normal latency.
- R10: Requests are taken only while idle, and simultaneous requests are ranked sleep, then nap, then start. Requests seen while busy are dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and read |
| nap_i | input | 1 | Request the light power-down sequence |
| sleep_i | input | 1 | Request the deep power-down sequence |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion start / power command line |
| sck_o | output | 1 | Serial read clock, idles low |
| data_o | output | DATA_W | Last result, MSB first order restored |
| valid_o | output | 1 | One-cycle strobe for a new result |
| busy_o | output | 1 | A conversion, read or power command is in progress |

## Verification
A plain read's strobe is due C + 2·DATA_W·H edges after the accepting edge, and a post-sleep read's strobe adds another C + W edges. A power command keeps `busy_o` high for N·(C+G) cycles, where N is its pulse count. The bench raises each request half a cycle before an edge and samples on falling clock edges. Its latency counter therefore counts whole rising edges from acceptance and compares that count against these sums, which it computes itself. A converter model shifts the word out on the falling edges of `conv_o` and `sck_o`, giving zeros after the LSB. Monitors count pulse widths and edges, and the bench reads their counters a moment after each falling edge.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_PWR,
    ST_WAKE,
    ST_RECOV
  } ctl_state_t;

  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;

  // edges from accepting a read to its valid strobe
  function automatic int frame_cycles(int conv_cyc, int sck_half, int bits);
    return conv_cyc + 2 * bits * sck_half;
  endfunction

  // busy cycles of a power command
  function automatic int pwr_cycles(int pulses, int conv_cyc, int gap_cyc);
    return pulses * (conv_cyc + gap_cyc);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] ph;
  logic          ph_end;

  assign ph_end   = (ph == PW'(HALF - 1));
  assign rise_evt = run && ph_end && !sck;
  assign fall_evt = run && ph_end && sck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (ph_end) begin
      ph  <= '0;
      sck <= ~sck;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);

endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         sdo,
  output logic [W-1:0] word,
  output logic         full
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (take) begin
      word <= {word[W-2:0], sdo};
      cnt  <= cnt + 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full);

endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int CONV_CYC   = 94,
  parameter int SCK_HALF   = 2,
  parameter int GAP_CYC    = 4,
  parameter int SLEEP_WAIT = 275000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              nap_i,
  input  logic              sleep_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int TW        = $clog2(max3(CONV_CYC, GAP_CYC, SLEEP_WAIT) + 1);
  localparam int FRAME_CYC = frame_cycles(CONV_CYC, SCK_HALF, DATA_W);
  localparam int FW        = $clog2(FRAME_CYC + 1);

  ctl_state_t        state;
  logic [TW-1:0]     tmr;
  logic              conv_q, asleep_q, is_sleep, valid_q;
  logic [2:0]        pulse_left;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic              idle, hit_conv, hit_gap, hit_wait;
  logic              sck_rise, sck_fall, bits_full, frame_done;
  logic [DATA_W-1:0] shift_word;

  assign idle       = (state == ST_IDLE);
  assign hit_conv   = (tmr == TW'(CONV_CYC - 1));
  assign hit_gap    = (tmr == TW'(GAP_CYC - 1));
  assign hit_wait   = (tmr == TW'(SLEEP_WAIT - 1));
  assign frame_done = (state == ST_SHIFT) && sck_fall && bits_full;

  sar_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_SHIFT),
    .sck      (sck_o),
    .rise_evt (sck_rise),
    .fall_evt (sck_fall)
  );

  sar_shift #(.W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle),
    .take  (sck_rise),
    .sdo   (sdo_i),
    .word  (shift_word),
    .full  (bits_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      conv_q     <= 1'b0;
      asleep_q   <= 1'b0;
      is_sleep   <= 1'b0;
      valid_q    <= 1'b0;
      pulse_left <= '0;
      data_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (sleep_i) begin
            state      <= ST_PWR;
            conv_q     <= 1'b1;
            is_sleep   <= 1'b1;
            pulse_left <= 3'(SLEEP_PULSES - 1);
          end else if (nap_i) begin
            state      <= ST_PWR;
            conv_q     <= 1'b1;
            is_sleep   <= 1'b0;
            pulse_left <= 3'(NAP_PULSES - 1);
          end else if (start_i) begin
            conv_q <= 1'b1;
            state  <= asleep_q ? ST_WAKE : ST_CONV;
          end
        end
        ST_CONV: begin
          if (hit_conv) begin
            conv_q <= 1'b0;
            tmr    <= '0;
            state  <= ST_SHIFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (frame_done) begin
            state   <= ST_IDLE;
            valid_q <= 1'b1;
            data_q  <= shift_word;
          end
        end
        ST_PWR: begin
          if (conv_q) begin
            if (hit_conv) begin
              conv_q <= 1'b0;
              tmr    <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else if (hit_gap) begin
            tmr <= '0;
            if (pulse_left == 3'd0) begin
              state    <= ST_IDLE;
              asleep_q <= asleep_q | is_sleep;
            end else begin
              conv_q     <= 1'b1;
              pulse_left <= pulse_left - 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAKE: begin
          if (hit_conv) begin
            conv_q <= 1'b0;
            tmr    <= '0;
            state  <= ST_RECOV;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_RECOV: begin
          if (hit_wait) begin
            tmr      <= '0;
            conv_q   <= 1'b1;
            asleep_q <= 1'b0;
            state    <= ST_CONV;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign conv_o  = conv_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign busy_o  = !idle;

  // checker counters
  logic [TW-1:0] hi_run;
  logic [FW-1:0] frm_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run  <= '0;
      frm_cnt <= '0;
    end else begin
      hi_run  <= conv_q ? hi_run + 1'b1 : '0;
      frm_cnt <= (state == ST_CONV || state == ST_SHIFT) ? frm_cnt + 1'b1 : '0;
    end
  end

  // R2
  conv_sck_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> !sck_o);

  // R2
  conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_o && hi_run != '0) |-> (hi_run == TW'(CONV_CYC)));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o));

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frm_cnt == FW'(FRAME_CYC - 1)));

  // R6
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o || sck_o) |-> busy_o);

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !asleep_q);

endmodule

// File: tb/tb_sar_read_ctrl.sv
`timescale 1ns/1ps
module tb_sar_read_ctrl;
  localparam int DW = 14;
  localparam int C  = 5;
  localparam int H  = 2;
  localparam int G  = 3;
  localparam int W  = 40;
  localparam int LAT      = C + DW * (2 * H);
  localparam int WAKE_LAT = C + W + LAT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start_i, nap_i, sleep_i, sdo_i;
  logic conv_o, sck_o, valid_o, busy_o;
  logic [DW-1:0] data_o;

  sar_read_ctrl #(.DATA_W(DW), .CONV_CYC(C), .SCK_HALF(H), .GAP_CYC(G), .SLEEP_WAIT(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nap_i(nap_i), .sleep_i(sleep_i),
    .sdo_i(sdo_i), .conv_o(conv_o), .sck_o(sck_o), .data_o(data_o),
    .valid_o(valid_o), .busy_o(busy_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model: MSB on conv fall, next bit per sck fall, zeros after LSB
  logic [DW-1:0] dev_word = '0;
  int dev_idx = -1;
  initial sdo_i = 1'b0;
  always @(negedge conv_o) begin
    dev_idx = DW - 1;
    sdo_i = dev_word[DW-1];
  end
  always @(negedge sck_o) begin
    if (dev_idx > 0) begin
      dev_idx = dev_idx - 1;
      sdo_i = dev_word[dev_idx];
    end else begin
      dev_idx = -1;
      sdo_i = 1'b0;
    end
  end

  // monitors
  int conv_rise = 0, sck_rise = 0, sck_fall = 0, valid_cnt = 0, busy_cnt = 0;
  int conv_bad = 0, sck_bad = 0, overlap_bad = 0;
  int conv_run = 0, sck_run = 0;
  logic conv_p = 1'b0, sck_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_o && !conv_p) conv_rise++;
      if (sck_o && !sck_p) sck_rise++;
      if (!sck_o && sck_p) sck_fall++;
      if (valid_o) valid_cnt++;
      if (busy_o) busy_cnt++;
      if (conv_o && sck_o) overlap_bad++;
      if (conv_o) conv_run++;
      else begin
        if (conv_run != 0 && conv_run != C) conv_bad++;
        conv_run = 0;
      end
      if (sck_o) sck_run++;
      else begin
        if (sck_run != 0 && sck_run != H) sck_bad++;
        sck_run = 0;
      end
      conv_p = conv_o;
      sck_p = sck_o;
    end
  end

  task automatic do_sample(input logic [DW-1:0] w, input int exp_lat, input string req, input bit inject);
    int n, cr0, sr0, sf0, b0, cb0, sb0, ob0;
    #1;
    cr0 = conv_rise; sr0 = sck_rise; sf0 = sck_fall; b0 = busy_cnt;
    cb0 = conv_bad; sb0 = sck_bad; ob0 = overlap_bad;
    dev_word = w;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    n = 0;
    while (!valid_o && n < 5000) begin
      if (inject && n == 10) sleep_i = 1'b1;
      if (inject && n == 11) sleep_i = 1'b0;
      @(negedge clk);
      n++;
    end
    sleep_i = 1'b0;
    check(n == exp_lat, req, "valid latency", n, exp_lat);
    check(data_o == w, "R4", "captured word", int'(data_o), int'(w));
    check(busy_o == 1'b0, "R6", "busy in valid cycle", int'(busy_o), 0);
    #1;
    check(busy_cnt - b0 == exp_lat, "R6", "busy cycles", busy_cnt - b0, exp_lat);
    check(sck_rise - sr0 == DW && sck_fall - sf0 == DW, "R3", "sck edges",
          (sck_rise - sr0) * 100 + (sck_fall - sf0), DW * 100 + DW);
    check(conv_bad == cb0 && overlap_bad == ob0, "R2", "conv width / sck static",
          conv_bad - cb0 + overlap_bad - ob0, 0);
    check(sck_bad == sb0, "R3", "sck high width", sck_bad - sb0, 0);
    check(conv_rise - cr0 == ((exp_lat == WAKE_LAT) ? 2 : 1), req, "conv pulses",
          conv_rise - cr0, (exp_lat == WAKE_LAT) ? 2 : 1);
    @(negedge clk);
    check(valid_o == 1'b0 && data_o == w, "R5", "one-cycle strobe, held data",
          int'(valid_o), 0);
  endtask

  task automatic pwr_cmd(input bit st, input bit np, input bit sl, input int pulses, input string req);
    int n, cr0, sr0, v0, b0;
    #1;
    cr0 = conv_rise; sr0 = sck_rise; v0 = valid_cnt; b0 = busy_cnt;
    @(negedge clk) begin start_i = st; nap_i = np; sleep_i = sl; end
    @(negedge clk) begin start_i = 1'b0; nap_i = 1'b0; sleep_i = 1'b0; end
    n = 0;
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    #1;
    check(conv_rise - cr0 == pulses, req, "power pulses", conv_rise - cr0, pulses);
    check(busy_cnt - b0 == pulses * (C + G), req, "power busy cycles", busy_cnt - b0, pulses * (C + G));
    check(sck_rise - sr0 == 0, req, "sck static during command", sck_rise - sr0, 0);
    check(valid_cnt - v0 == 0, req, "no strobe on command", valid_cnt - v0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cr0;
    rst_n = 1'b0; start_i = 1'b0; nap_i = 1'b0; sleep_i = 1'b0;
    repeat (4) @(negedge clk);
    check(!conv_o && !sck_o && !valid_o && !busy_o, "R1", "outputs in reset",
          int'({conv_o, sck_o, valid_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!conv_o && !sck_o && !valid_o && !busy_o, "R1", "outputs after reset",
          int'({conv_o, sck_o, valid_o, busy_o}), 0);

    // R4 sweep: extremes, walking patterns, spread values
    do_sample('0, LAT, "R5", 1'b0);
    do_sample('1, LAT, "R5", 1'b0);
    for (int i = 0; i < DW; i++) do_sample(DW'(1) << i, LAT, "R5", 1'b0);
    for (int i = 0; i < DW; i++) do_sample(~(DW'(1) << i), LAT, "R5", 1'b0);
    for (int k = 0; k < 120; k++) do_sample(DW'(k * 4099 + 77), LAT, "R5", 1'b0);

    // R7 nap then plain read
    pwr_cmd(1'b0, 1'b1, 1'b0, 2, "R7");
    do_sample(14'h2A5B, LAT, "R7", 1'b0);

    // R10 priority: all three -> sleep
    pwr_cmd(1'b1, 1'b1, 1'b1, 4, "R10");
    do_sample(14'h1C3D, WAKE_LAT, "R9", 1'b0);
    do_sample(14'h0F0F, LAT, "R9", 1'b0);

    // R10 nap beats start
    pwr_cmd(1'b1, 1'b1, 1'b0, 2, "R10");
    do_sample(14'h3001, LAT, "R10", 1'b0);

    // R8 sleep, then nap keeps recovery pending (R9)
    pwr_cmd(1'b0, 1'b0, 1'b1, 4, "R8");
    pwr_cmd(1'b0, 1'b1, 1'b0, 2, "R7");
    do_sample(14'h2222, WAKE_LAT, "R9", 1'b0);

    // R10 sleep request during a read is dropped
    do_sample(14'h1357, LAT, "R10", 1'b1);
    #1;
    cr0 = conv_rise;
    repeat (20) @(negedge clk);
    #1;
    check(conv_rise == cr0 && !busy_o, "R10", "dropped request starts nothing", conv_rise - cr0, 0);
    do_sample(14'h3FFE, LAT, "R10", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule